// File: doc/BRIEF.md
# Register-Addressed Serial Command Port

This block is the slave side of the serial port on a data converter peripheral. It sits between a host using a four-wire serial bus (active-low select, serial clock, data in, and one output pin that carries both read data and a ready flag) and the converter core. The core delivers each finished result as a one-cycle valid strobe with a data word. Every access opens with an 8-bit command byte. That byte picks a register and a direction. The block then shifts the 8-bit mode register in or out, returns an 8-bit status byte, or shifts out the stored result.

All serial pins are sampled in the system clock domain and edge-detected, so the serial clock must run well below the system clock. The block supports a streaming mode in which each new result leaves on the next data-width clocks without a command byte. It also supports a recovery path: a long run of ones on data in returns the whole port to its power-on state, whatever the interface was doing.

Top module: `cmd_serial_port`

## Requirements
- R1: The command byte is taken MSB first. Bit 7 is a start gate and must be 0. Bits 5:4 select the register. Bit 3 selects read when 1 and write when 0. Bit 2 requests streaming. Bits 1:0 are the channel, which appears on `chan_o` and in status bits 1:0.
- R2: While the port waits for a command, a 1 received as the first bit leaves the bit position unchanged. Only a 0 there starts collecting the remaining seven bits.
- R3: Register select works as follows. 00 reads status, or on a write updates the command fields only. 01 reads or writes the mode register. 10 is reserved, and 11 reads the data register. Writes to 10 or 11 change no register.
- R4: A mode write takes the 8 bits that follow the command, MSB first. It updates `mode_o` after the eighth rising edge and deasserts ready.
- R5: The status byte is {not_ready, 0, 0, 0, 1, 0, chan[1:0]}. After reset the mode register is 0x02 and the status byte is 0x88.
- R6: A data read returns the stored result MSB first over DATA_W bits. When it completes, ready deasserts.
- R7: Data in is captured on the rising edge of the serial clock. The output changes after the falling edge. `dout_en_o` is high exactly while `cs_ni` is low.
- R8: With select low and no read in progress, `dout_o` shows the inverted ready flag. It is 0 when an unread result is held.
- R9: A `res_valid_i` pulse stores `res_data_i` and asserts ready.
- R10: Select going high abandons any partial byte. The next access starts with a fresh command.
- R11: RST_ONES consecutive rising edges with data in high, taken while select is low, reset mode, status, data and streaming state to their power-on values. One edge fewer does not.
- R12: Command 0011_11xx enters streaming. Each new result is shifted out on the next DATA_W clocks without a command byte. It is sent once, and clocks given while not ready return ones.
- R13: While streaming, 0011_10xx received in the first eight bits of a result frame leaves streaming. A run of RST_ONES ones still resets the port.
- R14: A 1 in command bit 6 is ignored, and the command is decoded from its other fields.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cs_ni | input | 1 | Serial select, active low |
| sclk_i | input | 1 | Serial clock, idles high |
| din_i | input | 1 | Serial data in |
| dout_o | output | 1 | Serial data out / inverted ready |
| dout_en_o | output | 1 | Output driver enable (high-impedance when 0) |
| res_valid_i | input | 1 | Converter result strobe |
| res_data_i | input | DATA_W | Converter result word |
| mode_o | output | 8 | Mode register contents |
| chan_o | output | 2 | Channel field of last command |

## Verification
The bench builds the port with its defaults: a 16-bit result and a 32-edge reset run. The full run length is therefore reachable, and both 31 ones followed by a command and 32 ones ending in a reset are exercised. The 16-bit width makes streamed frames long enough to carry an 8-bit exit command inside one frame. It also lets a second 16-clock frame, given while not ready, show that a result leaves only once.

// File: rtl/cmd_serial_pkg.sv
package cmd_serial_pkg;
  localparam int REG_W = 8;
  localparam logic [REG_W-1:0] MODE_RST = 8'h02;

  typedef enum logic [1:0] {
    ST_CMD,
    ST_WR,
    ST_RD
  } port_state_e;

  typedef enum logic [1:0] {
    SEL_STAT = 2'b00,
    SEL_MODE = 2'b01,
    SEL_RSVD = 2'b10,
    SEL_DATA = 2'b11
  } reg_sel_e;
endpackage

// File: rtl/sclk_edge_det.sv
module sclk_edge_det (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cs_ni,
  input  logic sclk_i,
  output logic rise_o,
  output logic fall_o
);
  logic sclk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sclk_q <= 1'b1;
    else         sclk_q <= sclk_i;
  end

  assign rise_o = !cs_ni &&  sclk_i && !sclk_q;
  assign fall_o = !cs_ni && !sclk_i &&  sclk_q;
endmodule

// File: rtl/ones_run_det.sv
module ones_run_det #(
  parameter int RUN_LEN = 32
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cs_ni,
  input  logic rise_i,
  input  logic din_i,
  output logic hit_o
);
  localparam int CW = $clog2(RUN_LEN + 1);
  logic [CW-1:0] run_q;

  assign hit_o = rise_i && din_i && (run_q == CW'(RUN_LEN - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             run_q <= '0;
    else if (cs_ni || hit_o) run_q <= '0;
    else if (rise_i)         run_q <= din_i ? run_q + 1'b1 : '0;
  end

  AST_RUN_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q < CW'(RUN_LEN)); // R11
endmodule

// File: rtl/dout_shifter.sv
module dout_shifter #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         shift_i,
  output logic         bit_o
);
  logic [W-1:0] sr_q;
  logic [W-1:0] src;

  assign src = load_i ? load_val_i : sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q  <= '0;
      bit_o <= 1'b1;
    end else if (clr_i) begin
      sr_q  <= '0;
      bit_o <= 1'b1;
    end else if (shift_i) begin
      bit_o <= src[W-1];
      sr_q  <= src << 1;
    end else if (load_i) begin
      sr_q  <= load_val_i;
    end
  end
endmodule

// File: rtl/cmd_serial_port.sv
module cmd_serial_port
  import cmd_serial_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int RST_ONES = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_ni,
  input  logic              sclk_i,
  input  logic              din_i,
  output logic              dout_o,
  output logic              dout_en_o,
  input  logic              res_valid_i,
  input  logic [DATA_W-1:0] res_data_i,
  output logic [REG_W-1:0]  mode_o,
  output logic [1:0]        chan_o
);
  localparam int CNT_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] LAST_BYTE = CNT_W'(REG_W - 1);
  localparam logic [CNT_W-1:0] LAST_WORD = CNT_W'(DATA_W - 1);

  logic sclk_rise, sclk_fall, soft_rst;

  port_state_e       state_q;
  logic [CNT_W-1:0]  cnt_q, rd_last_q;
  logic [REG_W-1:0]  sr_q, mode_q;
  logic [DATA_W-1:0] data_q;
  logic [1:0]        chan_q;
  logic              rdy_n_q, crd_q, crd_frame_q, rd_data_q;

  logic [REG_W-1:0]  cmd_next;
  reg_sel_e          sel;
  logic              dec_fire, crd_start, load_en, shift_en, exit_hit;
  logic [DATA_W-1:0] load_val;
  logic [REG_W-1:0]  stat_byte;

  sclk_edge_det i_edge (
    .clk_i, .rst_ni, .cs_ni, .sclk_i,
    .rise_o (sclk_rise),
    .fall_o (sclk_fall)
  );

  ones_run_det #(.RUN_LEN(RST_ONES)) i_ones (
    .clk_i, .rst_ni, .cs_ni,
    .rise_i (sclk_rise),
    .din_i,
    .hit_o  (soft_rst)
  );

  assign cmd_next  = {sr_q[REG_W-2:0], din_i};
  assign sel       = reg_sel_e'(cmd_next[5:4]);
  assign stat_byte = {rdy_n_q, 3'b000, 1'b1, 1'b0, cmd_next[1:0]};
  // bit 6 of an exit command is don't-care, like any command
  assign exit_hit  = cmd_next[7] == 1'b0 && cmd_next[5:2] == 4'b1110;

  assign dec_fire  = state_q == ST_CMD && !crd_q && sclk_rise && cnt_q == LAST_BYTE;
  assign crd_start = state_q == ST_CMD && crd_q && !rdy_n_q && sclk_fall;

  always_comb begin
    load_en  = crd_start;
    load_val = data_q;
    if (dec_fire && cmd_next[3]) begin
      unique case (sel)
        SEL_STAT: begin load_en = 1'b1; load_val = {stat_byte, {(DATA_W-REG_W){1'b0}}}; end
        SEL_MODE: begin load_en = 1'b1; load_val = {mode_q,    {(DATA_W-REG_W){1'b0}}}; end
        SEL_DATA: load_en = !cmd_next[2];
        default:  load_en = 1'b0;
      endcase
    end
  end

  assign shift_en = crd_start || (state_q == ST_RD && sclk_fall);

  dout_shifter #(.W(DATA_W)) i_shift (
    .clk_i, .rst_ni,
    .clr_i      (soft_rst),
    .load_i     (load_en),
    .load_val_i (load_val),
    .shift_i    (shift_en),
    .bit_o      ()
  );

  logic shift_bit;
  assign shift_bit = i_shift.bit_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_CMD; cnt_q <= '0; rd_last_q <= '0; sr_q <= '0;
      mode_q <= MODE_RST; data_q <= '0; chan_q <= '0; rdy_n_q <= 1'b1;
      crd_q <= 1'b0; crd_frame_q <= 1'b0; rd_data_q <= 1'b0;
    end else if (soft_rst) begin
      state_q <= ST_CMD; cnt_q <= '0; rd_last_q <= '0; sr_q <= '0;
      mode_q <= MODE_RST; data_q <= '0; chan_q <= '0; rdy_n_q <= 1'b1;
      crd_q <= 1'b0; crd_frame_q <= 1'b0; rd_data_q <= 1'b0;
    end else begin
      if (res_valid_i) data_q <= res_data_i;
      if (cs_ni) begin
        state_q <= ST_CMD;
        cnt_q   <= '0;
      end else begin
        unique case (state_q)
          ST_CMD: begin
            if (crd_start) begin
              state_q <= ST_RD; cnt_q <= '0; rd_last_q <= LAST_WORD;
              rd_data_q <= 1'b1; crd_frame_q <= 1'b1;
            end else if (!crd_q && sclk_rise && !(cnt_q == '0 && din_i)) begin
              sr_q <= cmd_next;
              if (cnt_q != LAST_BYTE) cnt_q <= cnt_q + 1'b1;
              else begin
                cnt_q <= '0;
                chan_q <= cmd_next[1:0];
                crd_frame_q <= 1'b0;
                if (cmd_next[3]) begin
                  unique case (sel)
                    SEL_STAT, SEL_MODE: begin
                      state_q <= ST_RD; rd_last_q <= LAST_BYTE; rd_data_q <= 1'b0;
                    end
                    SEL_DATA:
                      if (cmd_next[2]) crd_q <= 1'b1;
                      else begin
                        state_q <= ST_RD; rd_last_q <= LAST_WORD; rd_data_q <= 1'b1;
                      end
                    default: ;
                  endcase
                end else if (sel == SEL_MODE) begin
                  state_q <= ST_WR;
                end
              end
            end
          end
          ST_WR: if (sclk_rise) begin
            sr_q <= cmd_next;
            if (cnt_q != LAST_BYTE) cnt_q <= cnt_q + 1'b1;
            else begin
              mode_q <= cmd_next; rdy_n_q <= 1'b1;
              state_q <= ST_CMD; cnt_q <= '0;
            end
          end
          ST_RD: if (sclk_rise) begin
            if (crd_frame_q && cnt_q <= LAST_BYTE) begin
              sr_q <= cmd_next;
              if (cnt_q == LAST_BYTE && exit_hit) crd_q <= 1'b0;
            end
            if (cnt_q != rd_last_q) cnt_q <= cnt_q + 1'b1;
            else begin
              state_q <= ST_CMD; cnt_q <= '0;
              if (rd_data_q) rdy_n_q <= 1'b1;
            end
          end
          default: state_q <= ST_CMD;
        endcase
      end
      if (res_valid_i) rdy_n_q <= 1'b0;
    end
  end

  assign dout_o    = (state_q == ST_RD) ? shift_bit : rdy_n_q;
  assign dout_en_o = !cs_ni;
  assign mode_o    = mode_q;
  assign chan_o    = chan_q;

  AST_PARK_FIRST_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_CMD && !crd_q && cnt_q == '0 && sclk_rise && din_i && !soft_rst)
    |=> (cnt_q == '0)); // R2
  AST_CS_ABORT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_ni |=> (state_q == ST_CMD && cnt_q == '0)); // R10
  AST_MODE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != ST_WR && !soft_rst) |=> $stable(mode_q)); // R4
  AST_SOFT_RST_DEFAULTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_rst |=> (mode_q == MODE_RST && rdy_n_q && !crd_q && data_q == '0)); // R11
  AST_RDY_FROM_RESULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(rdy_n_q) |-> $past(res_valid_i)); // R9
  AST_STREAM_NEEDS_RDY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(crd_frame_q) && crd_q) |-> $past(!rdy_n_q)); // R12
endmodule

// File: tb/test_cmd_serial_port.sv
module test_cmd_serial_port;
  localparam int DATA_W = 16;

  logic clk = 1'b0, rst_ni = 1'b0, cs_ni = 1'b1, sclk = 1'b1, din = 1'b0;
  logic res_valid = 1'b0;
  logic [DATA_W-1:0] res_data = '0;
  logic dout, dout_en;
  logic [7:0] mode;
  logic [1:0] chan;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  cmd_serial_port #(.DATA_W(DATA_W), .RST_ONES(32)) i_cmd_serial_port (
    .clk_i(clk), .rst_ni, .cs_ni, .sclk_i(sclk), .din_i(din),
    .dout_o(dout), .dout_en_o(dout_en), .res_valid_i(res_valid),
    .res_data_i(res_data), .mode_o(mode), .chan_o(chan)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic xfer(input logic [31:0] tx, input int n, output logic [31:0] rx);
    rx = '0;
    for (int i = n - 1; i >= 0; i--) begin
      sclk = 1'b0; din = tx[i];
      wait_clk(4);
      rx = {rx[30:0], dout};
      sclk = 1'b1;
      wait_clk(4);
    end
    din = 1'b0;
  endtask

  task automatic result(input logic [DATA_W-1:0] d);
    res_data = d; res_valid = 1'b1;
    wait_clk(1);
    res_valid = 1'b0;
    wait_clk(2);
  endtask

  task automatic access(input logic [7:0] cmd, input int len, input logic [31:0] tx,
                        output logic [31:0] rx);
    logic [31:0] dummy;
    cs_ni = 1'b0; wait_clk(2);
    xfer({24'h0, cmd}, 8, dummy);
    rx = '0;
    if (len > 0) xfer(tx, len, rx);
    cs_ni = 1'b1; wait_clk(3);
  endtask

  // {cmd, len, tx, expected}; checked when the command is a read with data bits
  localparam int NV = 12;
  localparam logic [44:0] VEC [NV] = '{
    {8'h08, 5'd8, 16'h0000, 16'h0088},  // status after reset
    {8'h10, 5'd8, 16'h0082, 16'h0000},  // mode write
    {8'h18, 5'd8, 16'h0000, 16'h0082},  // mode read back
    {8'h03, 5'd0, 16'h0000, 16'h0000},  // command-only write, channel 3
    {8'h0B, 5'd8, 16'h0000, 16'h008B},  // status shows channel 3
    {8'h4B, 5'd8, 16'h0000, 16'h008B},  // bit 6 set
    {8'h10, 5'd8, 16'h0002, 16'h0000},
    {8'h58, 5'd8, 16'h0000, 16'h0002},  // bit 6 set on mode read
    {8'h20, 5'd0, 16'h0000, 16'h0000},  // reserved select write
    {8'h18, 5'd8, 16'h0000, 16'h0002},
    {8'h30, 5'd0, 16'h0000, 16'h0000},  // write to read-only data
    {8'h18, 5'd8, 16'h0000, 16'h0002}
  };

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] rx;
    wait_clk(3);
    check("R7 hi-z while deselected", {31'b0, dout_en}, 32'd0);
    check("R5 mode reset value", {24'b0, mode}, 32'h02);
    rst_ni = 1'b1;
    wait_clk(3);
    cs_ni = 1'b0; wait_clk(3);
    check("R7 driven while selected", {31'b0, dout_en}, 32'd1);
    check("R8 idle shows not ready", {31'b0, dout}, 32'd1);
    cs_ni = 1'b1; wait_clk(3);

    for (int i = 0; i < NV; i++) begin
      access(VEC[i][44:37], int'(VEC[i][36:32]), {16'h0, VEC[i][31:16]}, rx);
      if (VEC[i][40] && VEC[i][36:32] != 0)
        check($sformatf("R1 R3 R4 R5 R14 vector %0d", i), rx, {16'h0, VEC[i][15:0]});
    end
    check("R1 channel output", {30'b0, chan}, 32'd0);

    // R9 R6 R8
    result(16'hA5C3);
    cs_ni = 1'b0; wait_clk(3);
    check("R8 idle shows ready", {31'b0, dout}, 32'd0);
    cs_ni = 1'b1; wait_clk(3);
    access(8'h38, 16, 32'h0, rx);
    check("R9 R6 data read", rx, 32'hA5C3);
    cs_ni = 1'b0; wait_clk(3);
    check("R6 ready cleared after read", {31'b0, dout}, 32'd1);

    // R2: leading ones park, then status read
    xfer({21'h0, 3'b111, 8'h08}, 11, rx);
    xfer(32'h0, 8, rx);
    check("R2 parked on leading ones", rx, 32'h88);
    cs_ni = 1'b1; wait_clk(3);

    // R10: abandoned half command
    cs_ni = 1'b0; wait_clk(2);
    xfer(32'h1, 4, rx);
    cs_ni = 1'b1; wait_clk(3);
    access(8'h08, 8, 32'h0, rx);
    check("R10 fresh command after abort", rx, 32'h88);

    // R11: 31 ones then command, then 32 ones
    access(8'h10, 8, 32'h82, rx);
    result(16'h1234);
    cs_ni = 1'b0; wait_clk(2);
    xfer(32'hFFFF_FFFE, 32, rx);
    xfer(32'h18, 7, rx);
    xfer(32'h0, 8, rx);
    check("R11 31 ones keep mode", rx, 32'h82);
    xfer(32'hFFFF_FFFF, 32, rx);
    cs_ni = 1'b1; wait_clk(3);
    check("R11 mode output after run", {24'b0, mode}, 32'h02);
    access(8'h18, 8, 32'h0, rx);
    check("R11 mode reg after run", rx, 32'h02);
    access(8'h08, 8, 32'h0, rx);
    check("R11 status after run", rx, 32'h88);
    access(8'h38, 16, 32'h0, rx);
    check("R11 data cleared", rx, 32'h0);

    // R12 streaming
    cs_ni = 1'b0; wait_clk(2);
    xfer(32'h3C, 8, rx);
    result(16'hBEEF);
    check("R8 ready while streaming", {31'b0, dout}, 32'd0);
    xfer(32'h0, 16, rx);
    check("R12 streamed result", rx, 32'hBEEF);
    xfer(32'h0, 16, rx);
    check("R12 result sent once", rx, 32'hFFFF);
    result(16'h0F0F);
    xfer(32'h0, 16, rx);
    check("R12 next streamed result", rx, 32'h0F0F);

    // R13 exit inside a frame
    result(16'h5555);
    xfer(32'h3800, 16, rx);
    check("R13 frame carrying exit", rx, 32'h5555);
    result(16'h7777);
    xfer(32'h0, 16, rx);
    check("R13 no stream after exit", rx, 32'h0);
    xfer(32'h38, 8, rx);
    xfer(32'h0, 16, rx);
    check("R13 normal read after exit", rx, 32'h7777);
    cs_ni = 1'b1; wait_clk(3);

    // R13 ones run while streaming
    access(8'h10, 8, 32'h82, rx);
    cs_ni = 1'b0; wait_clk(2);
    xfer(32'h3C, 8, rx);
    xfer(32'hFFFF_FFFF, 32, rx);
    cs_ni = 1'b1; wait_clk(3);
    access(8'h18, 8, 32'h0, rx);
    check("R13 ones run resets in streaming", rx, 32'h02);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule